// File: doc/BRIEF.md
# Vector Zero-Terminated String Isolator

This unit treats a 128-bit vector as a short string of byte or halfword characters and cuts it at the first zero character. A scan direction picks which end of the vector is the start of the string. Every element from that start up to and including the first zero element is passed through. Every element beyond it is cleared. If the vector holds no zero element, it passes through unchanged.

When the record input is set, the unit also returns a 4-bit condition nibble that tells whether a terminator was found. A result is captured on the clock edge after a valid input. The output holds its value until the next valid input arrives. With the `OUT_REG` parameter set to 0, the output register is left out and the unit is purely combinational.

Top module: `str_isolate`

## Requirements
- R1: `op_i` selects the operation. `op_i[1]`=0 means byte elements (16 per vector) and `op_i[1]`=1 means halfword elements (8 per vector). `op_i[0]`=0 means a left scan and `op_i[0]`=1 means a right scan. Element e occupies bits [e*W+W-1 : e*W], where W is the element width.
- R2: A left scan starts at the most significant element and moves toward element 0. The result keeps the first zero element found and every element more significant than it. Every less significant element is cleared.
- R3: A right scan starts at element 0 and moves upward. The result keeps the first zero element found and every element less significant than it. Every more significant element is cleared.
- R4: In halfword mode, an element counts as zero only when all 16 of its bits are zero. A zero byte inside a nonzero halfword does not end the string.
- R5: When no element is zero, `vec_o` equals the input vector.
- R6: With `rec_i`=1, `cc_o` is 4'b0010 when a zero element was found and 4'b0000 when none was found.
- R7: With `rec_i`=0, `cc_o` is 4'b0000 whatever the vector holds.
- R8: `valid_o` is high in the cycle after each cycle in which `valid_i` is high, and low otherwise. While `valid_i` is low, `vec_o` and `cc_o` keep their values.
- R9: After reset, `valid_o`, `vec_o` and `cc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector is valid this cycle |
| op_i | input | 2 | Element size and scan direction |
| rec_i | input | 1 | Produce the condition nibble |
| vec_i | input | 128 | Source vector |
| valid_o | output | 1 | Result is valid |
| vec_o | output | 128 | Isolated string |
| cc_o | output | 4 | Condition nibble |

## Verification
The hardest cases to reach are those that depend on where the zero sits relative to the element boundaries. These include a halfword whose two bytes fall on either side of a zero-byte run, and a terminator placed on the very last element the scan visits. Fully random 128-bit words almost never contain a zero element, let alone one at a chosen lane. The stimulus therefore builds vectors element by element. It clears whole aligned lanes at a tunable rate and also plants lone zero bytes inside nonzero halfwords. Directed vectors then place the single zero at the first and last scan positions, for both directions and both sizes.

// File: rtl/str_isolate_pkg.sv
package str_isolate_pkg;
  localparam int unsigned VEC_W = 128;
  localparam logic [3:0] CC_HIT  = 4'b0010;
  localparam logic [3:0] CC_MISS = 4'b0000;

  typedef enum logic [1:0] {
    OP_B_LEFT  = 2'd0,
    OP_B_RIGHT = 2'd1,
    OP_H_LEFT  = 2'd2,
    OP_H_RIGHT = 2'd3
  } iso_op_e;
endpackage

// File: rtl/str_zero_scan.sv
// Priority search for first all-zero element; pos_o is 1-based, N+1 on miss.
module str_zero_scan #(
  parameter int unsigned N  = 16,
  parameter int unsigned EW = 8,
  localparam int unsigned PW = $clog2(N + 2)
) (
  input  logic [N*EW-1:0] vec_i,
  input  logic            from_right_i,
  output logic [PW-1:0]   pos_o,
  output logic            found_o
);
  logic [N-1:0] zero_e;

  for (genvar e = 0; e < N; e++) begin : g_zero
    assign zero_e[e] = (vec_i[e*EW +: EW] == '0);
  end

  always_comb begin
    pos_o   = PW'(N + 1);
    found_o = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (!found_o && zero_e[from_right_i ? j : (N - 1 - j)]) begin
        pos_o   = PW'(j + 1);
        found_o = 1'b1;
      end
    end
  end

  always_comb begin
    AST_SCAN_POS: assert (found_o == (pos_o <= PW'(N))); // R2
  end
endmodule

// File: rtl/str_len_mask.sv
// Keeps keep_i elements counted from the chosen end.
module str_len_mask #(
  parameter int unsigned N  = 16,
  parameter int unsigned EW = 8,
  localparam int unsigned KW = $clog2(N + 1)
) (
  input  logic [KW-1:0]   keep_i,
  input  logic            from_right_i,
  output logic [N*EW-1:0] mask_o
);
  for (genvar e = 0; e < N; e++) begin : g_lane
    logic in_left, in_right;
    assign in_right = ({1'b0, KW'(e)} < {1'b0, keep_i});
    assign in_left  = ({1'b0, KW'(e)} + {1'b0, keep_i} >= (KW + 1)'(N));
    assign mask_o[e*EW +: EW] = {EW{from_right_i ? in_right : in_left}};
  end

  always_comb begin
    AST_FULL_MASK: assert (keep_i != KW'(N) || (&mask_o)); // R5
  end
endmodule

// File: rtl/str_isolate.sv
module str_isolate
  import str_isolate_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             rec_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [3:0]       cc_o
);
  localparam int unsigned NB  = VEC_W / 8;
  localparam int unsigned NH  = VEC_W / 16;
  localparam int unsigned BPW = $clog2(NB + 2);
  localparam int unsigned HPW = $clog2(NH + 2);
  localparam int unsigned BKW = $clog2(NB + 1);
  localparam int unsigned HKW = $clog2(NH + 1);

  iso_op_e op;
  logic    from_right, half_sel;
  assign op         = iso_op_e'(op_i);
  assign from_right = (op == OP_B_RIGHT) || (op == OP_H_RIGHT);
  assign half_sel   = (op == OP_H_LEFT) || (op == OP_H_RIGHT);

  logic [BPW-1:0]   b_pos;
  logic [HPW-1:0]   h_pos;
  logic             b_found, h_found;
  logic [BKW-1:0]   b_keep;
  logic [HKW-1:0]   h_keep;
  logic [VEC_W-1:0] b_mask, h_mask;

  str_zero_scan #(.N(NB), .EW(8)) u_scan_b (
    .vec_i(vec_i), .from_right_i(from_right), .pos_o(b_pos), .found_o(b_found));
  str_zero_scan #(.N(NH), .EW(16)) u_scan_h (
    .vec_i(vec_i), .from_right_i(from_right), .pos_o(h_pos), .found_o(h_found));

  // keep count = position on hit, all elements on miss
  assign b_keep = b_found ? b_pos[BKW-1:0] : BKW'(NB);
  assign h_keep = h_found ? h_pos[HKW-1:0] : HKW'(NH);

  str_len_mask #(.N(NB), .EW(8)) u_mask_b (
    .keep_i(b_keep), .from_right_i(from_right), .mask_o(b_mask));
  str_len_mask #(.N(NH), .EW(16)) u_mask_h (
    .keep_i(h_keep), .from_right_i(from_right), .mask_o(h_mask));

  logic [VEC_W-1:0] res_vec;
  logic [3:0]       res_cc;
  logic             hit;
  assign hit     = half_sel ? h_found : b_found;
  assign res_vec = vec_i & (half_sel ? h_mask : b_mask);
  assign res_cc  = (rec_i && hit) ? CC_HIT : CC_MISS;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        vec_o   <= '0;
        cc_o    <= CC_MISS;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          vec_o <= res_vec;
          cc_o  <= res_cc;
        end
      end
    end

    AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(vec_o) && $stable(cc_o))); // R8
    AST_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> ((vec_o & ~$past(vec_i)) == '0)); // R2
    AST_MISS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && rec_i) |=> (cc_o != CC_MISS || vec_o == $past(vec_i))); // R5
    AST_NOREC_CC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !rec_i) |=> (cc_o == CC_MISS)); // R7
    AST_CC_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (cc_o == CC_MISS || cc_o == CC_HIT)); // R6
  end else begin : g_comb
    assign valid_o = valid_i;
    assign vec_o   = res_vec;
    assign cc_o    = res_cc;
  end
endmodule

// File: tb/str_isolate_tb.sv
module str_isolate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = 2'd0;
  logic         rec_i = 1'b0;
  logic [127:0] vec_i = '0;
  logic         valid_o;
  logic [127:0] vec_o;
  logic [3:0]   cc_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  str_isolate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .rec_i(rec_i), .vec_i(vec_i), .valid_o(valid_o), .vec_o(vec_o), .cc_o(cc_o));

  function automatic logic [127:0] lane(logic [127:0] v, int e, int w);
    logic [127:0] m;
    m = (w == 8) ? 128'hFF : 128'hFFFF;
    return (v >> (e * w)) & m;
  endfunction

  function automatic logic ref_found(logic [127:0] v, logic [1:0] op);
    int w = op[1] ? 16 : 8;
    int n = 128 / w;
    for (int e = 0; e < n; e++) if (lane(v, e, w) == '0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [127:0] ref_vec(logic [127:0] v, logic [1:0] op);
    int w = op[1] ? 16 : 8;
    int n = 128 / w;
    logic [127:0] r = '0;
    logic done = 1'b0;
    for (int j = 0; j < n; j++) begin
      int e = op[0] ? j : n - 1 - j;
      if (!done) r |= lane(v, e, w) << (e * w);
      if (lane(v, e, w) == '0) done = 1'b1;
    end
    return r;
  endfunction

  task automatic chk_vec(string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s vec act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_small(string req, string what, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // one transaction; outputs sampled at the negedge after the capture edge
  task automatic run(string req, logic [127:0] v, logic [1:0] op, logic rec);
    logic [3:0] exp_cc;
    @(negedge clk);
    valid_i = 1'b1; vec_i = v; op_i = op; rec_i = rec;
    @(negedge clk);
    valid_i = 1'b0;
    exp_cc = (rec && ref_found(v, op)) ? 4'b0010 : 4'b0000;
    chk_small(req, "valid", {3'b0, valid_o}, 4'd1);
    chk_vec(req, vec_o, ref_vec(v, op));
    chk_small(req, "cc", cc_o, exp_cc);
  endtask

  function automatic logic [127:0] gen_vec(int zero_pct, bit half_aligned);
    logic [127:0] v;
    for (int b = 0; b < 16; b++) begin
      logic [7:0] x = 8'(($urandom % 255) + 1);
      v[b*8 +: 8] = x;
    end
    for (int h = 0; h < 8; h++) begin
      if (($urandom % 100) < 32'(zero_pct)) begin
        if (half_aligned) v[h*16 +: 16] = '0;
        else v[h*16 + 8*($urandom % 2) +: 8] = '0;
      end
    end
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] last_o;
    logic [3:0]   last_cc;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    // R9 reset state
    chk_small("R9", "valid", {3'b0, valid_o}, 4'd0);
    chk_vec("R9", vec_o, '0);
    chk_small("R9", "cc", cc_o, 4'd0);
    rst_n = 1'b1;

    // R1 R2 byte left: zero at first scanned element (msb) and last (lsb)
    run("R2", {8'h00, {15{8'hA5}}}, 2'd0, 1'b1);
    run("R2", {{15{8'h5A}}, 8'h00}, 2'd0, 1'b1);
    run("R2", 128'h1111_2222_3333_0044_5555_6666_7777_8888, 2'd0, 1'b1);
    // R3 byte right
    run("R3", {{15{8'hC3}}, 8'h00}, 2'd1, 1'b1);
    run("R3", {8'h00, {15{8'h3C}}}, 2'd1, 1'b1);
    run("R3", 128'h1111_2222_3333_0044_5555_6666_0077_8888, 2'd1, 1'b1);
    // R4 halfword: unaligned zero bytes are not terminators
    run("R4", 128'h1111_2222_3300_0044_5555_0000_7777_8888, 2'd2, 1'b1);
    run("R4", 128'h1111_0000_3300_0044_5555_6666_7700_8888, 2'd3, 1'b1);
    run("R4", {16'h0000, {7{16'h1234}}}, 2'd2, 1'b1);
    run("R4", {{7{16'h4321}}, 16'h0000}, 2'd2, 1'b1);
    run("R4", {16'h0000, {7{16'h1234}}}, 2'd3, 1'b1);
    // R5 R6 no zero at all, each op
    for (int o = 0; o < 4; o++) run("R5", {16{8'h81}}, 2'(o), 1'b1);
    run("R6", 128'h0, 2'd3, 1'b1);
    // R7 record off with terminator present
    run("R7", {8'h00, {15{8'hFF}}}, 2'd0, 1'b0);
    // R8 hold while idle, with different inputs presented
    last_o = vec_o; last_cc = cc_o;
    @(negedge clk);
    vec_i = ~vec_i; op_i = 2'd3; rec_i = 1'b1;
    @(negedge clk);
    chk_small("R8", "valid idle", {3'b0, valid_o}, 4'd0);
    chk_vec("R8", vec_o, last_o);
    chk_small("R8", "cc hold", cc_o, last_cc);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] op = 2'($urandom % 4);
      run(op[1] ? "R4" : (op[0] ? "R3" : "R2"),
          gen_vec(int'($urandom % 40), bit'($urandom % 2)), op, 1'($urandom % 2));
    end
    // R8 back-to-back valid
    @(negedge clk);
    valid_i = 1'b1; vec_i = {8'h00, {15{8'h77}}}; op_i = 2'd1; rec_i = 1'b1;
    @(negedge clk);
    chk_vec("R8", vec_o, ref_vec({8'h00, {15{8'h77}}}, 2'd1));
    vec_i = {{15{8'h66}}, 8'h00}; op_i = 2'd0;
    @(negedge clk);
    valid_i = 1'b0;
    chk_small("R8", "valid b2b", {3'b0, valid_o}, 4'd1);
    chk_vec("R8", vec_o, ref_vec({{15{8'h66}}, 8'h00}, 2'd0));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule